// File: doc/BRIEF.md
# Exception Entry and Return Sequencer

This block decides when the processor leaves its normal flow for an exception handler and when it comes back. It watches seven exception request lines and an instruction-complete strobe, picks one request, and issues the entry writes to a register file it does not own. Those writes save the current status word into the banked saved-status slot of the target mode, put the return address into that mode's link slot, load a rewritten current status word and load the program counter with the vector for the exception. On a return command it copies the saved status word of the current mode back into the current status word and loads the program counter from the current mode's link slot.

Every accepted entry or return drives its write strobes and a flush pulse for exactly one cycle. The cycle after that is a settle cycle in which the block accepts nothing, so the register file has committed the new status word before the next decision is made. Banked slots are named by the 5-bit mode code of the bank. The bank to read for a return is presented on `rd_bank`, and the register file answers combinationally on `spsr_rdata` and `lr_rdata`.

Top module: `exc_seq`

## Requirements
- R1: After reset, every write strobe (`psr_we`, `spsr_we`, `lr_we`, `pc_we`) and `flush` are low.
- R2: A reset request is taken at the next clock edge even when `insn_done` is low. It enters mode 0x13 with status bits 7 and 6 both set. The link slot receives `ret_addr` and the saved slot receives the old status word.
- R3: Every other exception request, and a return command, is acted on only at an edge where `insn_done` is high.
- R4: The program counter is loaded with VEC_BASE + 4*code, where VEC_BASE is zero by default. The codes are reset 0, undefined 1, software interrupt 2, prefetch abort 3, data abort 4, IRQ 6, FIQ 7.
- R5: The target mode code is written to status bits [4:0] and used as the saved-slot and link-slot bank. The codes are 0x13 for reset and software interrupt, 0x1B for undefined, 0x17 for either abort, 0x12 for IRQ and 0x11 for FIQ.
- R6: The new status word has bit 7 (IRQ mask) set and bit 5 (compact-state flag) cleared. Bit 6 (FIQ mask) is set for reset and FIQ and is kept unchanged for the other kinds. Bits above 7 are kept unchanged.
- R7: An IRQ request is ignored while status bit 7 is set. An FIQ request is ignored while status bit 6 is set.
- R8: Among requests taken together, the winner follows this order from highest to lowest: reset, data abort, FIQ, IRQ, prefetch abort, undefined, software interrupt.
- R9: An accepted return writes `spsr_rdata` to the status word and `lr_rdata` to the program counter, makes no saved-slot or link-slot write, and pulses `flush`.
- R10: A return command is ignored when the current mode is 0x10 or 0x1F. An exception taken in the same cycle wins over the return.
- R11: Write strobes and `flush` last exactly one cycle. All inputs are ignored at the following edge.
- R12: The saved slot receives the status word presented at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the block's registers |
| req_rst | input | 1 | Reset exception request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| req_irq | input | 1 | Normal interrupt request |
| req_fiq | input | 1 | Fast interrupt request |
| insn_done | input | 1 | Current instruction completes this cycle |
| ret_cmd | input | 1 | Exception return command |
| ret_addr | input | AW | Address to place in the link slot on entry |
| cur_psr | input | DW | Current status word from the register file |
| rd_bank | output | 5 | Mode code of the bank read for a return |
| spsr_rdata | input | DW | Saved status word of bank `rd_bank` |
| lr_rdata | input | AW | Link slot of bank `rd_bank` |
| psr_we | output | 1 | Current status word write strobe |
| psr_wdata | output | DW | New current status word |
| spsr_we | output | 1 | Saved status slot write strobe |
| spsr_bank | output | 5 | Bank of the saved status write |
| spsr_wdata | output | DW | Saved status value |
| lr_we | output | 1 | Link slot write strobe |
| lr_bank | output | 5 | Bank of the link write |
| lr_wdata | output | AW | Link value |
| pc_we | output | 1 | Program counter load strobe |
| pc_wdata | output | AW | New program counter |
| flush | output | 1 | One-cycle pipeline flush pulse |

## Verification
On every cycle, the assertions check several properties. A reset request outside the settle cycle produces a supervisor entry with both masks set. Nothing is written at an edge without `insn_done` unless a reset request is present. Every entry masks IRQ, clears the compact-state flag and uses the same bank for both slots and the mode field. The saved word equals the status word of the previous cycle, and the flush pulse never lasts two cycles. The bench's scenarios are the only place that shows several things. They show the exact vector and mode for each kind, and the masking of IRQ and FIQ against each flag combination. They show the full priority order over every request subset, the refusal of returns from the two unbanked modes, and a complete entry-then-return round trip that restores the status word and program counter.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

   // exception kinds; the value is the vector slot index
   typedef enum logic [2:0] {
      EX_RST  = 3'd0,
      EX_UND  = 3'd1,
      EX_SWI  = 3'd2,
      EX_PABT = 3'd3,
      EX_DABT = 3'd4,
      EX_RSVD = 3'd5,
      EX_IRQ  = 3'd6,
      EX_FIQ  = 3'd7
   } exc_kind_e;

   localparam int MODE_W = 5;

   localparam logic [MODE_W-1:0] MD_USR = 5'h10;
   localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
   localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
   localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
   localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
   localparam logic [MODE_W-1:0] MD_UND = 5'h1B;
   localparam logic [MODE_W-1:0] MD_SYS = 5'h1F;

   // status word bit positions decoded by the rest of the core
   localparam int PSR_I = 7;
   localparam int PSR_F = 6;
   localparam int PSR_T = 5;

   function automatic logic [MODE_W-1:0] target_mode(input exc_kind_e k);
      logic [MODE_W-1:0] m;
      case (k)
         EX_UND:          m = MD_UND;
         EX_PABT, EX_DABT: m = MD_ABT;
         EX_IRQ:          m = MD_IRQ;
         EX_FIQ:          m = MD_FIQ;
         default:         m = MD_SVC;
      endcase
      return m;
   endfunction

   function automatic logic masks_fast(input exc_kind_e k);
      return (k == EX_RST) || (k == EX_FIQ);
   endfunction

endpackage

// File: rtl/exc_arb.sv
module exc_arb
   import exc_seq_pkg::*;
(
   input  logic      arm,
   input  logic      req_rst,
   input  logic      req_und,
   input  logic      req_swi,
   input  logic      req_pabt,
   input  logic      req_dabt,
   input  logic      req_irq,
   input  logic      req_fiq,
   input  logic      insn_done,
   input  logic      mask_i,
   input  logic      mask_f,
   output logic      take,
   output exc_kind_e kind
);
   localparam int N = 7;

   // candidate order is the priority order, slot 0 highest
   localparam logic [2:0] PRIO_KIND [N] = '{
      3'(EX_RST), 3'(EX_DABT), 3'(EX_FIQ), 3'(EX_IRQ),
      3'(EX_PABT), 3'(EX_UND), 3'(EX_SWI)
   };

   logic [N-1:0] cand;
   logic [N-1:0] blocked;
   logic [N-1:0] gnt;
   logic [2:0]   kind_bits;
   logic         sync_ok;

   assign sync_ok = arm & insn_done;

   always_comb begin
      cand[0] = arm & req_rst;
      cand[1] = sync_ok & req_dabt;
      cand[2] = sync_ok & req_fiq & ~mask_f;
      cand[3] = sync_ok & req_irq & ~mask_i;
      cand[4] = sync_ok & req_pabt;
      cand[5] = sync_ok & req_und;
      cand[6] = sync_ok & req_swi;
   end

   assign blocked[0] = 1'b0;

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_pri
         if (g > 0) begin : g_chain
            assign blocked[g] = blocked[g-1] | cand[g-1];
         end
         assign gnt[g] = cand[g] & ~blocked[g];
      end
   endgenerate

   always_comb begin
      kind_bits = '0;
      for (int i = 0; i < N; i++) begin
         if (gnt[i]) kind_bits = kind_bits | PRIO_KIND[i];
      end
   end

   assign take = |gnt;
   assign kind = exc_kind_e'(kind_bits);

endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
   import exc_seq_pkg::*;
#(
   parameter int DW       = 32,
   parameter int AW       = 32,
   parameter bit HIGH_VEC = 1'b0
)(
   input  exc_kind_e         kind,
   input  logic [DW-1:0]     cur_psr,
   output logic [DW-1:0]     psr_new,
   output logic [MODE_W-1:0] mode_new,
   output logic [AW-1:0]     vec
);
   localparam int SLOT_SH = 2;
   localparam int PAD_W   = AW - 3 - SLOT_SH;

   logic [AW-1:0] base;

   generate
      if (HIGH_VEC) begin : g_hi
         assign base = {{(AW-16){1'b1}}, 16'h0000};
      end else begin : g_lo
         assign base = '0;
      end
   endgenerate

   assign mode_new = target_mode(kind);
   assign vec      = base | {{PAD_W{1'b0}}, 3'(kind), {SLOT_SH{1'b0}}};

   always_comb begin
      psr_new               = cur_psr;
      psr_new[MODE_W-1:0]   = mode_new;
      psr_new[PSR_T]        = 1'b0;
      psr_new[PSR_I]        = 1'b1;
      if (masks_fast(kind)) psr_new[PSR_F] = 1'b1;
   end

endmodule

// File: rtl/exc_seq.sv
module exc_seq
   import exc_seq_pkg::*;
#(
   parameter int DW       = 32,
   parameter int AW       = 32,
   parameter bit HIGH_VEC = 1'b0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_rst,
   input  logic          req_und,
   input  logic          req_swi,
   input  logic          req_pabt,
   input  logic          req_dabt,
   input  logic          req_irq,
   input  logic          req_fiq,
   input  logic          insn_done,
   input  logic          ret_cmd,
   input  logic [AW-1:0] ret_addr,
   input  logic [DW-1:0] cur_psr,
   output logic [4:0]    rd_bank,
   input  logic [DW-1:0] spsr_rdata,
   input  logic [AW-1:0] lr_rdata,
   output logic          psr_we,
   output logic [DW-1:0] psr_wdata,
   output logic          spsr_we,
   output logic [4:0]    spsr_bank,
   output logic [DW-1:0] spsr_wdata,
   output logic          lr_we,
   output logic [4:0]    lr_bank,
   output logic [AW-1:0] lr_wdata,
   output logic          pc_we,
   output logic [AW-1:0] pc_wdata,
   output logic          flush
);
   generate
      if (DW < 8) begin : g_bad_dw
         $error("exc_seq: DW must hold the mode field and flag bits");
      end
      if (AW < 16) begin : g_bad_aw
         $error("exc_seq: AW must be at least 16");
      end
   endgenerate

   logic              busy_q;
   logic              take;
   exc_kind_e         kind;
   logic [DW-1:0]     ent_psr;
   logic [MODE_W-1:0] ent_mode;
   logic [AW-1:0]     ent_pc;
   logic [MODE_W-1:0] cur_mode;
   logic              banked_mode;
   logic              ret_ok;

   assign cur_mode    = cur_psr[MODE_W-1:0];
   assign rd_bank     = cur_mode;
   assign banked_mode = (cur_mode != MD_USR) && (cur_mode != MD_SYS);

   exc_arb u_arb (
      .arm       (~busy_q),
      .req_rst   (req_rst),
      .req_und   (req_und),
      .req_swi   (req_swi),
      .req_pabt  (req_pabt),
      .req_dabt  (req_dabt),
      .req_irq   (req_irq),
      .req_fiq   (req_fiq),
      .insn_done (insn_done),
      .mask_i    (cur_psr[PSR_I]),
      .mask_f    (cur_psr[PSR_F]),
      .take      (take),
      .kind      (kind)
   );

   exc_entry_calc #(
      .DW       (DW),
      .AW       (AW),
      .HIGH_VEC (HIGH_VEC)
   ) u_calc (
      .kind     (kind),
      .cur_psr  (cur_psr),
      .psr_new  (ent_psr),
      .mode_new (ent_mode),
      .vec      (ent_pc)
   );

   assign ret_ok = ~busy_q & ~take & insn_done & ret_cmd & banked_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         psr_we     <= 1'b0;
         spsr_we    <= 1'b0;
         lr_we      <= 1'b0;
         pc_we      <= 1'b0;
         psr_wdata  <= '0;
         spsr_bank  <= '0;
         spsr_wdata <= '0;
         lr_bank    <= '0;
         lr_wdata   <= '0;
         pc_wdata   <= '0;
      end else begin
         busy_q  <= take | ret_ok;
         psr_we  <= take | ret_ok;
         pc_we   <= take | ret_ok;
         spsr_we <= take;
         lr_we   <= take;
         if (take) begin
            psr_wdata  <= ent_psr;
            spsr_bank  <= ent_mode;
            spsr_wdata <= cur_psr;
            lr_bank    <= ent_mode;
            lr_wdata   <= ret_addr;
            pc_wdata   <= ent_pc;
         end else if (ret_ok) begin
            psr_wdata  <= spsr_rdata;
            pc_wdata   <= lr_rdata;
         end
      end
   end

   assign flush = busy_q;

endmodule

// File: rtl/exc_seq_chk.sv
module exc_seq_chk
   import exc_seq_pkg::*;
#(
   parameter int DW = 32
)(
   input logic          clk,
   input logic          rst_n,
   input logic          req_rst,
   input logic          insn_done,
   input logic [DW-1:0] cur_psr,
   input logic          psr_we,
   input logic [DW-1:0] psr_wdata,
   input logic          spsr_we,
   input logic [4:0]    spsr_bank,
   input logic [DW-1:0] spsr_wdata,
   input logic          lr_we,
   input logic [4:0]    lr_bank,
   input logic          pc_we,
   input logic          flush
);
   a_r2_reset_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_rst && !flush) |=> (pc_we && spsr_we && spsr_bank == MD_SVC
                               && psr_wdata[PSR_I] && psr_wdata[PSR_F]));

   a_r3_wait_for_done: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_rst && !insn_done) |=> (!pc_we && !psr_we));

   a_r6_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_we |-> (psr_wdata[PSR_I] && !psr_wdata[PSR_T]));

   a_r5_bank_agree: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_we |-> (lr_we && spsr_bank == lr_bank && psr_wdata[4:0] == spsr_bank));

   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !flush);

   a_r12_saved_word: assert property (@(posedge clk) disable iff (!rst_n)
      spsr_we |-> (spsr_wdata == $past(cur_psr)));

   a_r7_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
      (spsr_we && spsr_bank == MD_IRQ) |-> !$past(cur_psr[PSR_I]));

endmodule

bind exc_seq exc_seq_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_rst    (req_rst),
   .insn_done  (insn_done),
   .cur_psr    (cur_psr),
   .psr_we     (psr_we),
   .psr_wdata  (psr_wdata),
   .spsr_we    (spsr_we),
   .spsr_bank  (spsr_bank),
   .spsr_wdata (spsr_wdata),
   .lr_we      (lr_we),
   .lr_bank    (lr_bank),
   .pc_we      (pc_we),
   .flush      (flush)
);

// File: tb/exc_seq_bench.sv
module exc_seq_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic req_rst = 0, req_und = 0, req_swi = 0, req_pabt = 0;
   logic req_dabt = 0, req_irq = 0, req_fiq = 0;
   logic insn_done = 0, ret_cmd = 0;
   logic [31:0] ret_addr = '0;
   logic [31:0] cpsr = 32'h0000_00D3;
   logic [4:0]  rd_bank;
   logic [31:0] spsr_rd, lr_rd;
   logic        psr_we, spsr_we, lr_we, pc_we, flush;
   logic [31:0] psr_wdata, spsr_wdata, lr_wdata, pc_wdata;
   logic [4:0]  spsr_bank, lr_bank;

   logic        set_en = 0;
   logic [31:0] set_val = '0;
   logic [31:0] spsr_m [32];
   logic [31:0] lr_m [32];

   int checks = 0;
   int errors = 0;

   exc_seq u_exc_seq (
      .clk(clk), .rst_n(rst_n),
      .req_rst(req_rst), .req_und(req_und), .req_swi(req_swi),
      .req_pabt(req_pabt), .req_dabt(req_dabt), .req_irq(req_irq), .req_fiq(req_fiq),
      .insn_done(insn_done), .ret_cmd(ret_cmd), .ret_addr(ret_addr),
      .cur_psr(cpsr), .rd_bank(rd_bank), .spsr_rdata(spsr_rd), .lr_rdata(lr_rd),
      .psr_we(psr_we), .psr_wdata(psr_wdata),
      .spsr_we(spsr_we), .spsr_bank(spsr_bank), .spsr_wdata(spsr_wdata),
      .lr_we(lr_we), .lr_bank(lr_bank), .lr_wdata(lr_wdata),
      .pc_we(pc_we), .pc_wdata(pc_wdata), .flush(flush)
   );

   // register file model driven by the sequencer's write port
   always @(posedge clk) begin
      if (psr_we) cpsr <= psr_wdata;
      else if (set_en) cpsr <= set_val;
      if (spsr_we) spsr_m[spsr_bank] <= spsr_wdata;
      if (lr_we) lr_m[lr_bank] <= lr_wdata;
   end
   assign spsr_rd = spsr_m[rd_bank];
   assign lr_rd   = lr_m[rd_bank];

   task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // priority slot -> kind code; slot order reset,dabt,fiq,irq,pabt,und,swi
   function automatic int kcode(input int slot);
      case (slot)
         0: return 0; 1: return 4; 2: return 7; 3: return 6;
         4: return 3; 5: return 1; default: return 2;
      endcase
   endfunction

   function automatic logic [4:0] kmode(input int code);
      case (code)
         1: return 5'h1B;
         3, 4: return 5'h17;
         6: return 5'h12;
         7: return 5'h11;
         default: return 5'h13;
      endcase
   endfunction

   task automatic drive(input logic [6:0] rq, input logic done, input logic rt, input logic [31:0] ra);
      {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = rq;
      insn_done = done; ret_cmd = rt; ret_addr = ra;
      @(negedge clk);
   endtask

   task automatic idle();
      {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt, req_rst} = '0;
      insn_done = 0; ret_cmd = 0;
      @(negedge clk);
   endtask

   task automatic set_psr(input logic [31:0] v);
      set_en = 1; set_val = v;
      @(negedge clk);
      set_en = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk("R1 strobes idle", !(psr_we | spsr_we | lr_we | pc_we | flush),
          {27'd0, psr_we, spsr_we, lr_we, pc_we, flush}, 32'd0);

      // each kind against every I/F/T combination, then a return
      for (int k = 0; k < 7; k++) begin
         for (int f = 0; f < 8; f++) begin
            logic [31:0] p, ra, e_psr;
            int code;
            bit masked;
            p    = 32'h5000_0010 | (32'(f) << 5);
            ra   = 32'h0000_1000 + 32'(k * 64 + f * 4);
            code = kcode(k);
            set_psr(p);
            drive(7'(1 << k), 1'b1, 1'b0, ra);
            masked = (code == 6 && p[7]) || (code == 7 && p[6]);
            if (masked) begin
               chk("R7 masked request ignored", !pc_we && !spsr_we && !flush,
                   {31'd0, pc_we}, 32'd0);
               idle();
            end else begin
               e_psr = p;
               e_psr[4:0] = kmode(code);
               e_psr[5] = 1'b0;
               e_psr[7] = 1'b1;
               if (code == 0 || code == 7) e_psr[6] = 1'b1;
               chk("R4 vector", pc_we && pc_wdata == 32'(code * 4), pc_wdata, 32'(code * 4));
               chk("R5 banks", spsr_bank == kmode(code) && lr_bank == kmode(code),
                   {27'd0, spsr_bank}, {27'd0, kmode(code)});
               chk("R6 new status", psr_we && psr_wdata == e_psr, psr_wdata, e_psr);
               chk("R12 saved status", spsr_we && spsr_wdata == p, spsr_wdata, p);
               chk("R2 link value", lr_we && lr_wdata == ra, lr_wdata, ra);
               chk("R11 flush pulse", flush, {31'd0, flush}, 32'd1);
               idle();
               drive(7'd0, 1'b1, 1'b1, 32'd0);
               chk("R9 return status", psr_we && psr_wdata == p && !spsr_we && !lr_we,
                   psr_wdata, p);
               chk("R9 return pc", pc_we && pc_wdata == ra && flush, pc_wdata, ra);
               idle();
            end
         end
      end

      // R8 priority over every subset, R3 and R2 with and without completion
      for (int m = 1; m < 128; m++) begin
         int w;
         w = 0;
         for (int b = 6; b >= 0; b--) if (m[b]) w = b;
         set_psr(32'h0000_0010);
         drive(7'(m), 1'b1, 1'b0, 32'h2000);
         chk("R8 winner", pc_we && pc_wdata == 32'(kcode(w) * 4) && spsr_bank == kmode(kcode(w)),
             pc_wdata, 32'(kcode(w) * 4));
         idle();
         set_psr(32'h0000_0010);
         drive(7'(m), 1'b0, 1'b0, 32'h2000);
         if (m[0])
            chk("R2 reset without completion", pc_we && pc_wdata == 32'd0 && spsr_bank == 5'h13,
                pc_wdata, 32'd0);
         else
            chk("R3 held until completion", !pc_we && !psr_we, {31'd0, pc_we}, 32'd0);
         idle();
      end

      // R10 returns from unbanked modes are ignored
      set_psr(32'h0000_0010);
      drive(7'd0, 1'b1, 1'b1, 32'h0);
      chk("R10 return in mode 0x10", !pc_we && !psr_we && !flush, {31'd0, pc_we}, 32'd0);
      idle();
      set_psr(32'h0000_001F);
      drive(7'd0, 1'b1, 1'b1, 32'h0);
      chk("R10 return in mode 0x1F", !pc_we && !psr_we && !flush, {31'd0, pc_we}, 32'd0);
      idle();

      // R10 exception beats return; R3 return waits for completion
      set_psr(32'h0000_00D3);
      drive(7'b0100000, 1'b1, 1'b1, 32'h3000);
      chk("R10 exception wins", spsr_we && spsr_bank == 5'h1B && pc_wdata == 32'h4,
          pc_wdata, 32'h4);
      idle();
      set_psr(32'h0000_00D3);
      drive(7'd0, 1'b0, 1'b1, 32'h0);
      chk("R3 return needs completion", !pc_we && !flush, {31'd0, pc_we}, 32'd0);
      idle();

      // R11 settle cycle ignores a held request, then it is taken again
      set_psr(32'h0000_0010);
      drive(7'b1000000, 1'b1, 1'b0, 32'h5000);
      chk("R11 first edge taken", pc_we && pc_wdata == 32'h8, pc_wdata, 32'h8);
      @(negedge clk);
      chk("R11 settle edge ignored", !pc_we && !flush && !spsr_we, {31'd0, pc_we}, 32'd0);
      @(negedge clk);
      chk("R11 taken after settle", pc_we && pc_wdata == 32'h8, pc_wdata, 32'h8);
      idle();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule